// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recently used page translations for a memory management unit. Each entry maps a logical page number, qualified by a 3-bit address-space code, to a physical page frame, together with four attributes: invalid, supervisor-only, write-protected and non-cacheable. A lookup compares the request against every entry in parallel. One clock later the block reports exactly one outcome: a successful translation with its physical address, a miss, an invalid-descriptor fault or a protection fault.

An external table walker handles misses by loading a descriptor. The walker may also load a descriptor marked invalid, so that later accesses to that page fault at once instead of walking the tables again. A new entry goes to the lowest-indexed free slot. When no slot is free, a pseudo least-recently-used scheme picks the victim. Software maintenance uses three flush granularities: all entries, all entries of one address space, or the one page of one address space.

The page size is chosen at run time and ranges from 256 bytes to 32 KB. It sets how many low address bits pass straight through and how many bits take part in the tag compare.

Top module: `xlt_cache`

## Requirements
- R1: The cache holds ENTRIES (default 22) translations, and any of them can match any logical page.
- R2: An entry matches only if its stored address-space code equals the request's code and the tag bits at or above the page-size bound are equal.
- R3: A lookup presented in cycle N produces, in cycle N+1, rsp_valid together with exactly one of rsp_ok, rsp_miss, rsp_inv_fault or rsp_prot_fault. rsp_phys is zero unless rsp_ok is set. When two entries match, the lowest-indexed one answers.
- R4: page_sel = s selects a page of 2^(8+s) bytes. The low 8+s bits of rsp_phys come from the logical address, and the bits above them come from the stored frame.
- R5: A hit on an entry loaded with ld_invalid=1 gives rsp_inv_fault, and no translation is returned.
- R6: A hit on a valid entry gives rsp_prot_fault in two cases: a write to a write-protected entry, or a user access (space code bit 2 = 0) to a supervisor-only entry. Bit 2 = 1 marks a supervisor access.
- R7: rsp_inhibit is set only with rsp_ok, and only when the entry carries the non-cacheable attribute.
- R8: A load with no existing match fills the lowest-indexed empty entry. If every entry is full, it fills the lowest-indexed entry whose recently-used bit is clear. Lookup hits and loads set the touched entry's bit. When all bits would become set, only the bits touched in that cycle stay set.
- R9: A load whose address-space code and page already match an entry overwrites that entry rather than adding a duplicate.
- R10: A flush with fl_kind 0 or 3 invalidates every entry.
- R11: A flush with fl_kind 1 invalidates every entry whose address-space code equals fl_space.
- R12: A flush with fl_kind 2 invalidates the entries that match both fl_space and the page of fl_addr.
- R13: A flush in the same cycle as a load takes priority, and the load is dropped.
- R14: After reset no entry is valid and every response output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_sel | input | 3 | Page size code s; the page holds 2^(8+s) bytes |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write |
| lk_space | input | 3 | Lookup address-space code (bit 2 = supervisor) |
| lk_addr | input | 32 | Lookup logical address |
| ld_req | input | 1 | Load a descriptor |
| ld_space | input | 3 | Load address-space code |
| ld_addr | input | 32 | Load logical address |
| ld_phys | input | 32 | Load physical address (frame taken from bits 31:8) |
| ld_invalid | input | 1 | Descriptor is invalid |
| ld_super | input | 1 | Supervisor-only attribute |
| ld_wprot | input | 1 | Write-protect attribute |
| ld_noncache | input | 1 | Non-cacheable attribute |
| fl_req | input | 1 | Flush request |
| fl_kind | input | 2 | 0/3 all, 1 by space, 2 by space and page |
| fl_space | input | 3 | Flush address-space code |
| fl_addr | input | 32 | Flush logical address |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Successful translation |
| rsp_miss | output | 1 | No entry matched |
| rsp_inv_fault | output | 1 | Matched an invalid descriptor |
| rsp_prot_fault | output | 1 | Protection violation |
| rsp_inhibit | output | 1 | Translation is non-cacheable |
| rsp_phys | output | 32 | Physical address |

## Verification
The bench builds the block with its default parameters: 22 entries, 32-bit addresses and 3-bit space codes. With a 22-entry array, the random phase can use a pool of 32 pages to force steady eviction, and it reaches both the saturating reset of the recently-used bits and the empty-slot-first fill order. Every one of the eight page sizes is exercised in turn, which moves the pass-through boundary from bit 8 to bit 15. Lookups and loads are also mixed in the same cycle, so a single update can touch two entries.

// File: rtl/xlt_pkg.sv
`timescale 1ns/1ps
package xlt_pkg;
  localparam int unsigned MIN_PG_SHIFT = 8;

  typedef enum logic [1:0] {
    FLUSH_ALL     = 2'd0,
    FLUSH_SPACE   = 2'd1,
    FLUSH_PAGE    = 2'd2,
    FLUSH_ALL_ALT = 2'd3
  } flush_kind_e;

  typedef struct packed {
    logic inv;
    logic sup;
    logic wp;
    logic ci;
  } xlt_attr_t;
endpackage

// File: rtl/xlt_tag_cmp.sv
`timescale 1ns/1ps
module xlt_tag_cmp #(
  parameter int unsigned TAG_W = 24,
  parameter int unsigned FC_W  = 3
) (
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [FC_W-1:0]  ent_space,
  input  logic [TAG_W-1:0] q_tag,
  input  logic [FC_W-1:0]  q_space,
  input  logic [TAG_W-1:0] tag_mask,
  input  logic             use_tag,
  output logic             hit
);
  logic space_eq;
  logic tag_eq;

  assign space_eq = (ent_space == q_space);
  assign tag_eq   = (((ent_tag ^ q_tag) & tag_mask) == '0);
  assign hit      = ent_valid && space_eq && (!use_tag || tag_eq);
endmodule

// File: rtl/xlt_plru.sv
`timescale 1ns/1ps
module xlt_plru #(
  parameter int unsigned N     = 22,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ent_valid,
  input  logic [N-1:0]     clr,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  output logic [IDX_W-1:0] victim
);
  logic [N-1:0]     used_q;
  logic [N-1:0]     used_d;
  logic [N-1:0]     mark;
  logic [N-1:0]     merged;
  logic             used_en;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;
  logic             any_free;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mark[i] = (a_en && (a_idx == IDX_W'(i))) || (b_en && (b_idx == IDX_W'(i)));
    end
    merged  = (used_q & ~clr) | mark;
    used_d  = (&merged) ? mark : merged;
    used_en = (|mark) || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (used_en) begin
      used_q <= used_d;
    end
  end

  always_comb begin
    free_idx = '0;
    old_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDX_W'(i);
      if (!used_q[i])    old_idx  = IDX_W'(i);
    end
    any_free = ~(&ent_valid);
    victim   = any_free ? free_idx : old_idx;
  end

  // R8
  plru_not_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&used_q));

  // R8
  plru_touch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !(&((used_q & ~clr) | mark))) |=> (used_q[$past(a_idx)] == 1'b1));
endmodule

// File: rtl/xlt_resp.sv
`timescale 1ns/1ps
module xlt_resp
  import xlt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned FC_W   = 3,
  localparam int unsigned FRM_W = ADDR_W - MIN_PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              write,
  input  logic [FC_W-1:0]   space,
  input  logic [ADDR_W-1:0] va,
  input  logic              any_hit,
  input  xlt_attr_t         attr,
  input  logic [FRM_W-1:0]  frame,
  input  logic [ADDR_W-1:0] off_mask,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_miss,
  output logic              rsp_inv,
  output logic              rsp_prot,
  output logic              rsp_ci,
  output logic [ADDR_W-1:0] rsp_pa
);
  logic              deny;
  logic              ok_d, miss_d, inv_d, prot_d, ci_d;
  logic [ADDR_W-1:0] pa_d;
  logic [ADDR_W-1:0] frame_full;

  always_comb begin
    frame_full = {frame, {MIN_PG_SHIFT{1'b0}}};
    deny   = (write && attr.wp) || (!space[FC_W-1] && attr.sup);
    miss_d = req && !any_hit;
    inv_d  = req && any_hit && attr.inv;
    prot_d = req && any_hit && !attr.inv && deny;
    ok_d   = req && any_hit && !attr.inv && !deny;
    ci_d   = ok_d && attr.ci;
    pa_d   = ok_d ? ((frame_full & ~off_mask) | (va & off_mask)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_inv   <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_ci    <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= req;
      rsp_ok    <= ok_d;
      rsp_miss  <= miss_d;
      rsp_inv   <= inv_d;
      rsp_prot  <= prot_d;
      rsp_ci    <= ci_d;
      rsp_pa    <= pa_d;
    end
  end

  // R3
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);

  // R3
  resp_one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_ok, rsp_miss, rsp_inv, rsp_prot}) == 1));

  // R7
  resp_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ci |-> rsp_ok);

  // R6
  resp_wprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && any_hit && !attr.inv && write && attr.wp) |=> (rsp_prot && !rsp_ok));
endmodule

// File: rtl/xlt_cache.sv
`timescale 1ns/1ps
module xlt_cache
  import xlt_pkg::*;
#(
  parameter int unsigned ENTRIES = 22,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FC_W    = 3,
  parameter int unsigned PGSEL_W = 3,
  localparam int unsigned TAG_W  = ADDR_W - MIN_PG_SHIFT,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PGSEL_W-1:0] page_sel,
  input  logic              lk_req,
  input  logic              lk_write,
  input  logic [FC_W-1:0]   lk_space,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              ld_req,
  input  logic [FC_W-1:0]   ld_space,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [ADDR_W-1:0] ld_phys,
  input  logic              ld_invalid,
  input  logic              ld_super,
  input  logic              ld_wprot,
  input  logic              ld_noncache,
  input  logic              fl_req,
  input  logic [1:0]        fl_kind,
  input  logic [FC_W-1:0]   fl_space,
  input  logic [ADDR_W-1:0] fl_addr,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_miss,
  output logic              rsp_inv_fault,
  output logic              rsp_prot_fault,
  output logic              rsp_inhibit,
  output logic [ADDR_W-1:0] rsp_phys
);
  logic [ENTRIES-1:0] val_q, val_d;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FC_W-1:0]    space_q [ENTRIES];
  logic [TAG_W-1:0]   frame_q [ENTRIES];
  xlt_attr_t          attr_q  [ENTRIES];

  logic [TAG_W-1:0]   tag_mask;
  logic [ADDR_W-1:0]  off_mask;
  logic [ENTRIES-1:0] lk_hitv, ld_hitv, fl_cmpv, fl_kill, ld_we;
  logic [IDX_W-1:0]   lk_idx, dup_idx, victim, ld_slot;
  logic               lk_any, ld_any, ld_go, fl_by_page, fl_every, val_en;
  xlt_attr_t          ld_attr;
  flush_kind_e        fl_kind_e;

  // page-size dependent masks
  always_comb begin
    for (int i = 0; i < int'(TAG_W); i++) begin
      tag_mask[i] = (i >= int'(page_sel));
    end
    for (int j = 0; j < int'(ADDR_W); j++) begin
      off_mask[j] = (j < (int'(MIN_PG_SHIFT) + int'(page_sel)));
    end
  end

  assign fl_kind_e  = flush_kind_e'(fl_kind);
  assign fl_by_page = (fl_kind_e == FLUSH_PAGE);
  assign fl_every   = (fl_kind_e == FLUSH_ALL) || (fl_kind_e == FLUSH_ALL_ALT);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlt_tag_cmp #(.TAG_W(TAG_W), .FC_W(FC_W)) u_lk_cmp (
      .ent_valid (val_q[g]),
      .ent_tag   (tag_q[g]),
      .ent_space (space_q[g]),
      .q_tag     (lk_addr[ADDR_W-1:MIN_PG_SHIFT]),
      .q_space   (lk_space),
      .tag_mask  (tag_mask),
      .use_tag   (1'b1),
      .hit       (lk_hitv[g])
    );
    xlt_tag_cmp #(.TAG_W(TAG_W), .FC_W(FC_W)) u_ld_cmp (
      .ent_valid (val_q[g]),
      .ent_tag   (tag_q[g]),
      .ent_space (space_q[g]),
      .q_tag     (ld_addr[ADDR_W-1:MIN_PG_SHIFT]),
      .q_space   (ld_space),
      .tag_mask  (tag_mask),
      .use_tag   (1'b1),
      .hit       (ld_hitv[g])
    );
    xlt_tag_cmp #(.TAG_W(TAG_W), .FC_W(FC_W)) u_fl_cmp (
      .ent_valid (val_q[g]),
      .ent_tag   (tag_q[g]),
      .ent_space (space_q[g]),
      .q_tag     (fl_addr[ADDR_W-1:MIN_PG_SHIFT]),
      .q_space   (fl_space),
      .tag_mask  (tag_mask),
      .use_tag   (fl_by_page),
      .hit       (fl_cmpv[g])
    );
    assign fl_kill[g] = fl_req && val_q[g] && (fl_every || fl_cmpv[g]);
    assign ld_we[g]   = ld_go && (ld_slot == IDX_W'(g));
  end

  // lowest-index priority encoders
  always_comb begin
    lk_idx  = '0;
    dup_idx = '0;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (lk_hitv[i]) lk_idx  = IDX_W'(i);
      if (ld_hitv[i]) dup_idx = IDX_W'(i);
    end
    lk_any  = |lk_hitv;
    ld_any  = |ld_hitv;
    ld_go   = ld_req && !fl_req;
    ld_slot = ld_any ? dup_idx : victim;
    ld_attr = '{inv: ld_invalid, sup: ld_super, wp: ld_wprot, ci: ld_noncache};
  end

  xlt_plru #(.N(ENTRIES), .IDX_W(IDX_W)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_valid (val_q),
    .clr       (fl_kill),
    .a_en      (lk_req && lk_any && !fl_req),
    .a_idx     (lk_idx),
    .b_en      (ld_go),
    .b_idx     (ld_slot),
    .victim    (victim)
  );

  // valid bits: next state then register
  always_comb begin
    val_d  = (val_q & ~fl_kill) | ld_we;
    val_en = fl_req || ld_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  // entry payload storage, no reset needed (qualified by val_q)
  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (ld_we[i]) begin
        tag_q[i]   <= ld_addr[ADDR_W-1:MIN_PG_SHIFT];
        space_q[i] <= ld_space;
        frame_q[i] <= ld_phys[ADDR_W-1:MIN_PG_SHIFT];
        attr_q[i]  <= ld_attr;
      end
    end
  end

  xlt_resp #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (lk_req),
    .write     (lk_write),
    .space     (lk_space),
    .va        (lk_addr),
    .any_hit   (lk_any),
    .attr      (attr_q[lk_idx]),
    .frame     (frame_q[lk_idx]),
    .off_mask  (off_mask),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_miss  (rsp_miss),
    .rsp_inv   (rsp_inv_fault),
    .rsp_prot  (rsp_prot_fault),
    .rsp_ci    (rsp_inhibit),
    .rsp_pa    (rsp_phys)
  );

  // R10
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_every) |=> (val_q == '0));

  // R13
  flush_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> ((val_q & ~$past(val_q)) == '0));

  // R9
  reload_no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !fl_req && ld_any) |=> ($countones(val_q) == $past($countones(val_q))));

  // R14
  reset_empty_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (val_q == '0));
endmodule

// File: tb/xlt_cache_tb.sv
`timescale 1ns/1ps
module xlt_cache_tb;
  localparam int N = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  g_pg;
  logic        g_lk, g_wr, g_ld, g_inv, g_sup, g_wp, g_ci, g_fl;
  logic [2:0]  g_fc, g_lfc, g_ffc;
  logic [1:0]  g_fk;
  logic [31:0] g_va, g_lva, g_lpa, g_fva;
  logic        rsp_valid, rsp_ok, rsp_miss, rsp_inv_fault, rsp_prot_fault, rsp_inhibit;
  logic [31:0] rsp_phys;

  xlt_cache u_dut (
    .clk(clk), .rst_n(rst_n), .page_sel(g_pg),
    .lk_req(g_lk), .lk_write(g_wr), .lk_space(g_fc), .lk_addr(g_va),
    .ld_req(g_ld), .ld_space(g_lfc), .ld_addr(g_lva), .ld_phys(g_lpa),
    .ld_invalid(g_inv), .ld_super(g_sup), .ld_wprot(g_wp), .ld_noncache(g_ci),
    .fl_req(g_fl), .fl_kind(g_fk), .fl_space(g_ffc), .fl_addr(g_fva),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_miss(rsp_miss),
    .rsp_inv_fault(rsp_inv_fault), .rsp_prot_fault(rsp_prot_fault),
    .rsp_inhibit(rsp_inhibit), .rsp_phys(rsp_phys)
  );

  // reference model
  bit          m_v[N], m_used[N], m_inv[N], m_sup[N], m_wp[N], m_ci[N];
  logic [23:0] m_tag[N], m_frm[N];
  logic [2:0]  m_fc[N];

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit good, input string req, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] tmask(input logic [2:0] pg);
    logic [23:0] m;
    for (int i = 0; i < 24; i++) m[i] = (i >= int'(pg));
    return m;
  endfunction

  function automatic logic [31:0] omask(input logic [2:0] pg);
    logic [31:0] m;
    for (int j = 0; j < 32; j++) m[j] = (j < 8 + int'(pg));
    return m;
  endfunction

  function automatic int m_first(input logic [31:0] va, input logic [2:0] fc, input bit use_tag);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_fc[i] == fc && (!use_tag || ((m_tag[i] ^ va[31:8]) & tmask(g_pg)) == 0))
        return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (!m_used[i]) return i;
    return 0;
  endfunction

  function automatic logic [37:0] exp_resp();
    int k;
    logic [31:0] om;
    if (!g_lk) return '0;
    k = m_first(g_va, g_fc, 1'b1);
    if (k < 0) return {6'b101000, 32'h0};
    if (m_inv[k]) return {6'b100100, 32'h0};
    if ((g_wr && m_wp[k]) || (!g_fc[2] && m_sup[k])) return {6'b100010, 32'h0};
    om = omask(g_pg);
    return {4'b1100, 1'b0, m_ci[k], ({m_frm[k], 8'h00} & ~om) | (g_va & om)};
  endfunction

  task automatic model_update();
    bit mark[N];
    bit all;
    int k, s;
    for (int i = 0; i < N; i++) mark[i] = 1'b0;
    if (g_fl) begin
      for (int i = 0; i < N; i++)
        if (m_v[i] && (g_fk == 2'd0 || g_fk == 2'd3 || (m_fc[i] == g_ffc &&
            (g_fk == 2'd1 || ((m_tag[i] ^ g_fva[31:8]) & tmask(g_pg)) == 0)))) begin
          m_v[i] = 1'b0;
          m_used[i] = 1'b0;
        end
      return;
    end
    if (g_lk) begin
      k = m_first(g_va, g_fc, 1'b1);
      if (k >= 0) mark[k] = 1'b1;
    end
    if (g_ld) begin
      s = m_first(g_lva, g_lfc, 1'b1);
      if (s < 0) s = m_victim();
      m_v[s] = 1'b1; m_tag[s] = g_lva[31:8]; m_fc[s] = g_lfc; m_frm[s] = g_lpa[31:8];
      m_inv[s] = g_inv; m_sup[s] = g_sup; m_wp[s] = g_wp; m_ci[s] = g_ci;
      mark[s] = 1'b1;
    end
    all = 1'b1;
    for (int i = 0; i < N; i++) if (!(m_used[i] | mark[i])) all = 1'b0;
    for (int i = 0; i < N; i++) m_used[i] = all ? mark[i] : (m_used[i] | mark[i]);
  endtask

  task automatic clr();
    g_lk = 0; g_wr = 0; g_fc = 0; g_va = 0;
    g_ld = 0; g_lfc = 0; g_lva = 0; g_lpa = 0; g_inv = 0; g_sup = 0; g_wp = 0; g_ci = 0;
    g_fl = 0; g_fk = 0; g_ffc = 0; g_fva = 0;
  endtask

  task automatic set_look(input logic [31:0] va, input logic [2:0] fc, input bit wr);
    g_lk = 1; g_va = va; g_fc = fc; g_wr = wr;
  endtask

  task automatic set_load(input logic [31:0] va, input logic [2:0] fc, input logic [31:0] pa,
                          input bit inv, input bit sup, input bit wp, input bit ci);
    g_ld = 1; g_lva = va; g_lfc = fc; g_lpa = pa; g_inv = inv; g_sup = sup; g_wp = wp; g_ci = ci;
  endtask

  task automatic set_flush(input logic [1:0] kind, input logic [2:0] fc, input logic [31:0] va);
    g_fl = 1; g_fk = kind; g_ffc = fc; g_fva = va;
  endtask

  task automatic step(input string req);
    logic [37:0] exp, got;
    exp = exp_resp();
    @(posedge clk);
    #5;
    got = {rsp_valid, rsp_ok, rsp_miss, rsp_inv_fault, rsp_prot_fault, rsp_inhibit, rsp_phys};
    chk(got === exp, req, got, exp);
    model_update();
    clr();
  endtask

  task automatic look(input logic [31:0] va, input logic [2:0] fc, input bit wr, input string req);
    clr(); set_look(va, fc, wr); step(req);
  endtask

  function automatic logic [31:0] pg_addr(input int p);
    return {p[23:0], 8'h00} | ($urandom() & 32'hFF);
  endfunction

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [37:0] r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_used[i] = 0; end
    clr();
    g_pg = 3'd0;
    repeat (3) @(posedge clk);
    #5;
    r = {rsp_valid, rsp_ok, rsp_miss, rsp_inv_fault, rsp_prot_fault, rsp_inhibit, rsp_phys};
    chk(r == '0, "R14", r, '0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    look(32'h0000_1234, 3'd5, 0, "R14");

    // fill and hit all entries
    for (int k = 0; k < N; k++) begin
      clr(); set_load({k[23:0] + 24'd1, 8'h00}, 3'd5, {k[23:0] + 24'h800, 8'h00}, 0, 0, 0, 0);
      step("R1");
    end
    for (int k = 0; k < N; k++) look(pg_addr(k + 1), 3'd5, 0, "R1");
    look(pg_addr(1), 3'd1, 0, "R2");
    look(pg_addr(1), 3'd4, 0, "R2");

    // eviction and reload
    clr(); set_load(pg_addr(100), 3'd5, 32'h00AB_0000, 0, 0, 0, 0); step("R8");
    for (int k = 0; k < N; k++) look(pg_addr(k + 1), 3'd5, 0, "R8");
    clr(); set_load(pg_addr(101), 3'd5, 32'h00AC_0000, 0, 0, 0, 0); step("R8");
    look(pg_addr(101), 3'd5, 0, "R8");
    clr(); set_load(pg_addr(3), 3'd5, 32'h0FED_C000, 0, 0, 0, 0); step("R9");
    look(pg_addr(3), 3'd5, 0, "R9");
    clr(); set_load(pg_addr(3), 3'd5, 32'h0FED_D000, 0, 0, 0, 0); step("R9");
    look(pg_addr(3), 3'd5, 0, "R9");

    // attributes
    clr(); set_load(pg_addr(200), 3'd5, 32'h1111_1100, 1, 0, 0, 0); step("R5");
    look(pg_addr(200), 3'd5, 0, "R5");
    clr(); set_load(pg_addr(201), 3'd2, 32'h2222_2200, 0, 0, 1, 0); step("R6");
    look(pg_addr(201), 3'd2, 1, "R6");
    look(pg_addr(201), 3'd2, 0, "R6");
    clr(); set_load(pg_addr(202), 3'd6, 32'h3333_3300, 0, 1, 0, 0); step("R6");
    look(pg_addr(202), 3'd2, 0, "R6");
    clr(); set_load(pg_addr(202), 3'd2, 32'h3344_3300, 0, 1, 0, 0); step("R6");
    look(pg_addr(202), 3'd2, 0, "R6");
    look(pg_addr(202), 3'd6, 0, "R6");
    clr(); set_load(pg_addr(203), 3'd1, 32'h4444_4400, 0, 0, 0, 1); step("R7");
    look(pg_addr(203), 3'd1, 0, "R7");
    look(pg_addr(201), 3'd2, 0, "R7");

    // flushes
    clr(); set_flush(2'd1, 3'd5, 32'h0); step("R11");
    look(pg_addr(3), 3'd5, 0, "R11");
    look(pg_addr(201), 3'd2, 0, "R11");
    clr(); set_flush(2'd2, 3'd2, pg_addr(201)); step("R12");
    look(pg_addr(201), 3'd2, 0, "R12");
    look(pg_addr(202), 3'd2, 0, "R12");
    look(pg_addr(203), 3'd1, 0, "R12");
    clr(); set_flush(2'd0, 3'd0, 32'h0); step("R10");
    look(pg_addr(203), 3'd1, 0, "R10");
    look(pg_addr(202), 3'd6, 0, "R10");
    clr(); set_load(pg_addr(300), 3'd3, 32'h5555_5500, 0, 0, 0, 0); step("R10");
    clr(); set_flush(2'd3, 3'd0, 32'h0); step("R10");
    look(pg_addr(300), 3'd3, 0, "R10");
    clr(); set_flush(2'd0, 3'd0, 32'h0); set_load(pg_addr(301), 3'd3, 32'h6666_6600, 0, 0, 0, 0);
    step("R13");
    look(pg_addr(301), 3'd3, 0, "R13");

    // page sizes
    for (int s = 0; s < 8; s++) begin
      g_pg = 3'(s);
      clr(); set_flush(2'd0, 3'd0, 32'h0); step("R4");
      a = $urandom();
      clr(); set_load(a, 3'd6, $urandom(), 0, 0, 0, 0); step("R4");
      look(a ^ ($urandom() & omask(3'(s))), 3'd6, 0, "R4");
      look(a ^ (32'h1 << (8 + s)), 3'd6, 0, "R4");
    end

    // constrained random traffic
    g_pg = 3'd0;
    clr(); set_flush(2'd0, 3'd0, 32'h0); step("R10");
    for (int n = 0; n < 1500; n++) begin
      int op;
      logic [2:0] fcs [4];
      fcs[0] = 3'd1; fcs[1] = 3'd2; fcs[2] = 3'd5; fcs[3] = 3'd6;
      op = int'($urandom_range(0, 99));
      clr();
      if (op < 55) set_look(pg_addr(int'($urandom_range(0, 31))), fcs[$urandom_range(0, 3)], 1'($urandom()));
      if (op >= 35 && op < 97)
        set_load(pg_addr(int'($urandom_range(0, 31))), fcs[$urandom_range(0, 3)], $urandom(),
                 ($urandom_range(0, 9) == 0), 1'($urandom()), 1'($urandom()), 1'($urandom()));
      if (op >= 97)
        set_flush(2'($urandom_range(1, 2)), fcs[$urandom_range(0, 3)], pg_addr(int'($urandom_range(0, 31))));
      step("R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule